// File: doc/BRIEF.md
# Fractional Prescaler Baud Generator

This block produces the 16x baud enable for a serial port running from a 24 MHz reference clock. The reference first passes through a prescaler that can divide by 13, by 1.625 or by 1. The 1.625 ratio is not an integer, so it is built from a phase accumulator that lets 8 of every 13 reference cycles through. The prescaler output then clocks a 16-bit programmable divisor counter. Each time that counter wraps, the block raises `baud_tick` for one reference cycle. The tick is a clock enable in the reference domain, not a derived clock.

Software reaches the divisor through a small byte-wide register port with a combinational read path. A control byte holds the prescaler select, a divisor lock bit and a baud-test bit. When the lock is set and the port is in legacy (non-extended) mode, any access to the two divisor byte addresses is quietly steered to two scratchpad bytes, and the real divisor stays as it was. In extended mode the lock has no effect. The baud-test bit routes the tick onto the modem-control DTR output.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the control byte (address 2), both divisor bytes (addresses 0 and 1) and both scratchpad bytes read 0, and `baud_tick` is low.
- R2: With prescaler select (control bits 1:0) at 00, the prescaler passes one enable every 13 reference cycles. With divisor D, ticks are therefore exactly 13*D cycles apart.
- R3: With select 01, the prescaler passes 8 enables in every 13 reference cycles. With divisor 8, ticks are exactly 13 cycles apart.
- R4: With select 11, the prescaler passes every reference cycle. With divisor D, ticks are exactly D cycles apart.
- R5: The reserved select 10 behaves exactly like 00, so the tick never stalls.
- R6: A divisor of 0 acts as 65536.
- R7: Any divisor byte write that reaches the real divisor restarts the divisor count. With select 11 and the new divisor D, the first tick arrives D cycles after the write edge.
- R8: When the lock (control bit 2) is 1 and `ext_mode` is 0, reads and writes of addresses 0 and 1 go to two scratchpad bytes. The real divisor and the tick period stay unchanged.
- R9: When `ext_mode` is 1, the lock bit is ignored: addresses 0 and 1 reach the real divisor.
- R10: When baud-test (control bit 3) is 1, `dtr_out` equals `baud_tick`. Otherwise `dtr_out` equals `dtr_in`.
- R11: Every `baud_tick` pulse is preceded, one cycle earlier, by a prescaler enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 divisor low, 1 divisor high, 2 control, 3 reads 0 |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| ext_mode | input | 1 | Extended-mode flag; 1 disables divisor lock redirection |
| dtr_in | input | 1 | Normal DTR value from the modem-control logic |
| reg_rdata | output | 8 | Read data, 0 when `reg_rd` is low |
| baud_tick | output | 1 | Single-cycle 16x baud enable |
| dtr_out | output | 1 | DTR pin value, or the baud tick in test mode |

## Verification
Register reads are combinational, so the bench samples `reg_rdata` a moment after raising `reg_rd` in the same cycle. A write takes effect at the clock edge that ends its strobe cycle. With select 11, the first tick after a divisor write is due D edges later, because the count register and the tick register each add one stage; the reload check samples each falling edge and expects the tick exactly at the D-th edge. Period checks let the first tick after a reconfiguration set the baseline. After that the scoreboard compares every later interval against the queued expected period. `dtr_out` is combinational and is compared at each falling edge.

// File: rtl/baud_pkg.sv
// Shared definitions for the baud tick generator.
// Assumes an 8-bit register port with a 2-bit address.
package baud_pkg;

    typedef enum logic [1:0] {
        PS_DIV13 = 2'b00,
        PS_FRAC  = 2'b01,
        PS_RSVD  = 2'b10,
        PS_DIV1  = 2'b11
    } presel_e;

    localparam int          ADDR_W    = 2;
    localparam logic [1:0]  A_DIV_LO  = 2'd0;
    localparam logic [1:0]  A_DIV_HI  = 2'd1;
    localparam logic [1:0]  A_CTRL    = 2'd2;
    localparam int          LOCK_BIT  = 2;
    localparam int          TEST_BIT  = 3;

endpackage

// File: rtl/baud_regs.sv
// Register file: divisor bytes, scratchpad bytes and control byte.
// Assumes single-cycle write strobes. The read path is combinational.
// When the lock is set outside extended mode, divisor addresses hit scratchpads.
module baud_regs
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic              ext_mode,
    output logic [7:0]        rdata,
    output logic [DIV_W-1:0]  div,
    output presel_e           presel,
    output logic              btest,
    output logic              reload
);
    localparam int HI_W = DIV_W - 8;

    logic [7:0]       ctrl_q;
    logic [7:0]       scr_lo_q, scr_hi_q;
    logic [DIV_W-1:0] div_q;
    logic             redir;
    logic             div_addr;

    // Steering condition for divisor-address accesses
    assign redir    = ctrl_q[LOCK_BIT] && !ext_mode;
    assign div_addr = (addr == A_DIV_LO) || (addr == A_DIV_HI);
    assign reload   = wr && div_addr && !redir;

    // Register writes with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            scr_lo_q <= '0;
            scr_hi_q <= '0;
            div_q    <= '0;
        end else if (wr) begin
            case (addr)
                A_DIV_LO: if (redir) scr_lo_q <= wdata;
                          else       div_q[7:0] <= wdata;
                A_DIV_HI: if (redir) scr_hi_q <= wdata;
                          else       div_q[DIV_W-1:8] <= wdata[HI_W-1:0];
                A_CTRL:   ctrl_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Combinational read mux, zero when not reading
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                A_DIV_LO: rdata = redir ? scr_lo_q : div_q[7:0];
                A_DIV_HI: rdata = redir ? scr_hi_q : 8'(div_q[DIV_W-1:8]);
                A_CTRL:   rdata = ctrl_q;
                default:  rdata = '0;
            endcase
        end
    end

    assign div    = div_q;
    assign presel = presel_e'(ctrl_q[1:0]);
    assign btest  = ctrl_q[TEST_BIT];

    // Locked legacy access must leave the real divisor alone
    p_lock_holds_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && redir && div_addr) |=> $stable(div_q));

    // Extended mode writes reach the real divisor even when locked
    p_ext_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ext_mode && addr == A_DIV_LO) |=> (div_q[7:0] == $past(wdata)));

endmodule

// File: rtl/baud_presc.sv
// Prescaler: emits a one-cycle enable at 1/13, 8/13 or 1/1 of the clock rate.
// Assumes the select may change at any time; the phase state restarts
// whenever a mode is left.
module baud_presc
    import baud_pkg::*;
#(
    parameter int INT_DIV  = 13,
    parameter int FRAC_ADD = 8,
    parameter int FRAC_MOD = 13
) (
    input  logic    clk,
    input  logic    rst_n,
    input  presel_e sel,
    output logic    en
);
    localparam int CNT_W = $clog2(INT_DIV);
    localparam int ACC_W = $clog2(FRAC_MOD) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             en_q;
    logic             mode_int;

    assign mode_int = (sel == PS_DIV13) || (sel == PS_RSVD);
    assign sum      = acc_q + ACC_W'(FRAC_ADD);

    // Integer divider, fractional accumulator and registered enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
            en_q  <= 1'b0;
        end else begin
            cnt_q <= '0;
            acc_q <= '0;
            en_q  <= 1'b0;
            case (sel)
                PS_DIV1: en_q <= 1'b1;
                PS_FRAC: begin
                    if (sum >= ACC_W'(FRAC_MOD)) begin
                        acc_q <= sum - ACC_W'(FRAC_MOD);
                        en_q  <= 1'b1;
                    end else begin
                        acc_q <= sum;
                    end
                end
                default: begin
                    if (cnt_q == CNT_W'(INT_DIV - 1)) begin
                        en_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign en = en_q;

    // Accumulator stays below the modulus
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < ACC_W'(FRAC_MOD));

    // Integer mode never gives two enables in a row
    p_int_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_int) |=> (!en_q || !mode_int));

endmodule

// File: rtl/baud_divcnt.sv
// Divisor counter: counts prescaler enables and pulses tick on wrap.
// A divisor of 0 wraps at 2**DIV_W. A reload restarts the count from 0.
module baud_divcnt #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             presc_en,
    input  logic [DIV_W-1:0] div,
    input  logic             reload,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;
    logic             tick_q;

    assign last = div - 1'b1;

    // Count enables, wrap at divisor-1, register the tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (reload) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (presc_en) begin
            tick_q <= (cnt_q == last);
            cnt_q  <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    // A tick always follows a prescaler enable
    p_tick_after_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> $past(presc_en));

    // Reload restarts the count
    p_reload_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == '0 && !tick_q));

    // Count never passes the wrap point
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);

endmodule

// File: rtl/baud_tick_gen.sv
// Top: register port, prescaler, divisor counter and DTR test routing.
// Assumes a 24 MHz clk; baud_tick is an enable in that domain.
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int INT_DIV  = 13,
    parameter int FRAC_ADD = 8,
    parameter int FRAC_MOD = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        ext_mode,
    input  logic        dtr_in,
    output logic [7:0]  reg_rdata,
    output logic        baud_tick,
    output logic        dtr_out
);
    logic [DIV_W-1:0] div;
    presel_e          presel;
    logic             btest;
    logic             reload;
    logic             presc_en;

    baud_regs #(.DIV_W(DIV_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .wr(reg_wr), .rd(reg_rd), .ext_mode(ext_mode), .rdata(reg_rdata),
        .div(div), .presel(presel), .btest(btest), .reload(reload)
    );

    baud_presc #(.INT_DIV(INT_DIV), .FRAC_ADD(FRAC_ADD), .FRAC_MOD(FRAC_MOD)) i_presc (
        .clk(clk), .rst_n(rst_n), .sel(presel), .en(presc_en)
    );

    baud_divcnt #(.DIV_W(DIV_W)) i_divcnt (
        .clk(clk), .rst_n(rst_n), .presc_en(presc_en), .div(div),
        .reload(reload), .tick(baud_tick)
    );

    // DTR pin: baud tick in test mode, normal value otherwise
    assign dtr_out = btest ? baud_tick : dtr_in;

    // Tick and prescaler enable never appear without a reset-free history
    p_no_tick_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !baud_tick);

endmodule

// File: tb/test_baud_tick_gen.sv
// Scoreboard bench: driver tasks queue expected tick periods,
// a monitor measures tick intervals and compares against the queue.
module test_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic       ext_mode = 1'b0;
    logic       dtr_in = 1'b0;
    logic [7:0] reg_rdata;
    logic       baud_tick;
    logic       dtr_out;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    last_t = 0;
    bit    armed = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "";
    int    expq[$];

    baud_tick_gen i_baud_tick_gen (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .ext_mode(ext_mode), .dtr_in(dtr_in),
        .reg_rdata(reg_rdata), .baud_tick(baud_tick), .dtr_out(dtr_out)
    );

    always #5 clk = ~clk;

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Monitor: measure tick intervals and compare against queued periods
    always @(negedge clk) begin
        cyc++;
        if (rst_n && baud_tick) begin
            if (armed && expq.size() > 0) begin
                int e;
                e = expq.pop_front();
                check((cyc - last_t) == e, cur_tag, cyc - last_t, e);
            end
            last_t = cyc;
            armed  = 1'b1;
        end
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            check(1'b0, "watchdog", cyc, 190000);
            finish_run();
        end
    end

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
        reg_rd = 1'b0;
    endtask

    // Driver: queue n expected periods and wait for the monitor to drain them
    task automatic expect_periods(int p, int n, string tag);
        int lim;
        cur_tag = tag;
        armed = 1'b0;
        expq.delete();
        for (int i = 0; i < n; i++) expq.push_back(p);
        lim = p * (n + 2) + 50;
        for (int i = 0; i < lim && expq.size() > 0; i++) @(negedge clk);
        if (expq.size() > 0) check(1'b0, {tag, " missing ticks"}, expq.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(baud_tick == 1'b0, "R1 tick low", baud_tick, 0);
        rd_chk(2'd2, 8'h00, "R1 ctrl");
        rd_chk(2'd0, 8'h00, "R1 div lo");
        rd_chk(2'd1, 8'h00, "R1 div hi");

        // R7: reload timing with select 11, divisor 5
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h05);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check(baud_tick == (k == 5), "R7 first tick", baud_tick, k == 5);
        end
        // R4: divide by 1
        expect_periods(5, 4, "R4 div1 D=5");
        wr(2'd0, 8'h02);
        expect_periods(2, 4, "R4 div1 D=2");

        // R2: divide by 13
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h03);
        expect_periods(39, 3, "R2 div13 D=3");

        // R5: reserved code acts as divide by 13
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h03);
        expect_periods(39, 3, "R5 rsvd D=3");

        // R3: divide by 1.625
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h08);
        expect_periods(13, 4, "R3 frac D=8");
        wr(2'd0, 8'h10);
        expect_periods(26, 3, "R3 frac D=16");

        // R8: lock in legacy mode steers to scratchpads
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h05);
        wr(2'd2, 8'h07);
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h3C);
        rd_chk(2'd0, 8'hA5, "R8 scratch lo");
        rd_chk(2'd1, 8'h3C, "R8 scratch hi");
        rd_chk(2'd2, 8'h07, "R8 ctrl readback");
        expect_periods(5, 3, "R8 divisor kept");

        // R9: extended mode ignores the lock
        ext_mode = 1'b1;
        rd_chk(2'd0, 8'h05, "R9 real lo");
        wr(2'd0, 8'h07);
        expect_periods(7, 3, "R9 ext write");
        ext_mode = 1'b0;
        rd_chk(2'd0, 8'hA5, "R8 scratch kept");

        // R10: baud test routes tick to DTR
        wr(2'd2, 8'h0B);
        dtr_in = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(dtr_out == baud_tick, "R10 test dtr", dtr_out, baud_tick);
        end
        wr(2'd2, 8'h03);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            dtr_in = k[0];
            #1;
            check(dtr_out == dtr_in, "R10 normal dtr", dtr_out, dtr_in);
        end

        // R6: divisor 0 acts as 65536
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        expect_periods(65536, 1, "R6 div zero");

        done = 1'b1;
        finish_run();
    end
endmodule